// File: doc/BRIEF.md
# Per-Pin Vector Waveform Formatter

This block turns a stream of test vectors, one per tester period, into timed drive and compare activity on a group of bidirectional tester pins. Each vector carries one character per pin, a per-pin direction code, a table select and a period length in fine ticks. One clock cycle is one tick. Each character is looked up in the selected waveform table. The entry found there gives two drive actions with their tick times and one compare action with its tick time. A single vector can therefore produce a return-to-zero pulse or a strobe at any point in the period, and the timing can change on every period.

Each pin adds its own stimulus delay to both drive times and its own response delay to the receive time. This allows per-pin skew compensation and margin sweeps. The outputs are registered drive data and drive enable for each pin, plus fail flags. The fail flags are computed from two window-comparator inputs per pin, which report whether the received level is above the high threshold or below the low threshold. The next vector is taken through a valid/ready handshake during the last tick of the running period. If none is offered, the pins keep their state and a sticky underrun flag is raised.

Top module: `wf_formatter`

## Requirements
- R1: Reset is synchronous and active high. After reset every pin is released (`pin_oe` = 0), all fail flags and `underrun` are 0, and `vec_ready` is 1.
- R2: `vec_ready` is high while no period is running and during the last tick of a running period; it is low otherwise. A vector is accepted on a clock edge where `vec_valid` and `vec_ready` are both high. Tick 0 of its period is the next cycle, so back-to-back vectors run with no gap.
- R3: Drive edge 1 fires in the cycle where the period tick equals t1 plus the pin's stimulus delay; drive edge 2 does the same with t2. The result is visible on the pins from the following cycle. Drive codes: 0 drives low, 1 drives high, 2 enables the driver and keeps the last driven data, 3 releases the pin (enable off, data kept).
- R4: An edge whose delayed time is at or beyond the period length does not fire. A period length of 0 is treated as 1.
- R5: When both drive edges fall on the same tick, the action of drive edge 2 is the one that takes effect.
- R6: The receive edge fires at tick tr plus the pin's response delay. Compare codes: 0 means no compare; 1 passes only if `cmp_lo` is set; 2 passes only if `cmp_hi` is set; 3 (three-state) passes only if neither is set. On a mismatch, `pin_fail` for that pin and `vec_fail` go high in the following cycle. `vec_fail` lasts one cycle.
- R7: Direction codes per pin, per vector: 0 (input) turns every drive edge into a release; 1 (output) suppresses comparison; 2 and 3 (bidirectional) allow both driving and comparison.
- R8: Each vector selects one of `NTBL` tables with `vec_tsel`. A table row is written through the table write port at (`tbl_sel`, `tbl_chr`). The row is packed from the most significant bit down as drive code 1 (2 bits), drive code 2 (2), compare code (2), t1, t2, tr (`TICK_W` bits each).
- R9: Character code 0 is a fixed no-action character. It never drives or compares, whatever its table row holds.
- R10: If no vector is accepted at the last tick, the period stops and `underrun` is set and stays set until reset. While no period runs, `pin_oe` and `pin_do` hold their values.
- R11: A set `pin_fail` bit stays set until reset, across later passing periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table row write strobe |
| tbl_sel | input | TSEL_W | Table index for the write |
| tbl_chr | input | CHR_W | Character code for the write |
| tbl_data | input | ENT_W | Packed table row |
| vec_valid | input | 1 | Next vector offered |
| vec_ready | output | 1 | Vector can be accepted this cycle |
| vec_tsel | input | TSEL_W | Table used by the offered vector |
| vec_chars | input | NPINS*CHR_W | Character per pin, pin 0 in the low bits |
| vec_dir | input | NPINS*2 | Direction code per pin |
| vec_period | input | TICK_W | Period length in ticks |
| pin_sdly | input | NPINS*TICK_W | Stimulus delay per pin (0 to 254) |
| pin_rdly | input | NPINS*TICK_W | Response delay per pin (0 to 254) |
| cmp_hi | input | NPINS | Received level above the high threshold |
| cmp_lo | input | NPINS | Received level below the low threshold |
| pin_do | output | NPINS | Drive data |
| pin_oe | output | NPINS | Drive enable (0 = high-impedance) |
| pin_fail | output | NPINS | Sticky per-pin compare fail |
| vec_fail | output | 1 | One-cycle pulse on any compare mismatch |
| underrun | output | 1 | Sticky: a period ended with no next vector |

## Verification
The bench builds the block with four pins, four tables and sixteen characters. Four pins make room for a per-pin delay that grows by one tick per pin, so the same vector sees some pins fire an edge and others push it past the period end. Four tables make it cheap to switch tables between back-to-back vectors and between table-driven cases. The same rows can be reached through both the table select and the character code. A bench model of the requirements tracks drive state, sticky fails and the fail pulse for every tick and every pin.

// File: rtl/wf_pkg.sv
package wf_pkg;
  parameter int TICK_W = 8;

  typedef enum logic [1:0] {DRV_LOW = 2'd0, DRV_HIGH = 2'd1, DRV_HOLD = 2'd2, DRV_REL = 2'd3} drv_e;
  typedef enum logic [1:0] {CMP_NONE = 2'd0, CMP_LOW = 2'd1, CMP_HIGH = 2'd2, CMP_MID = 2'd3} cmp_e;
  typedef enum logic [1:0] {DIR_IN = 2'd0, DIR_OUT = 2'd1, DIR_BI = 2'd2, DIR_BI2 = 2'd3} dir_e;

  // one waveform table row
  typedef struct packed {
    drv_e              d1;
    drv_e              d2;
    cmp_e              cmp;
    logic [TICK_W-1:0] t1;
    logic [TICK_W-1:0] t2;
    logic [TICK_W-1:0] tr;
  } wave_ent_t;

  localparam int ENT_W = $bits(wave_ent_t);
endpackage

// File: rtl/wf_table_ram.sv
module wf_table_ram #(
  parameter int W     = 30,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wf_period_ctl.sv
module wf_period_ctl
  import wf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_valid,
  input  logic [TICK_W-1:0] vec_period,
  output logic              vec_ready,
  output logic              load,
  output logic              run,
  output logic [TICK_W-1:0] tick,
  output logic              underrun
);
  logic              run_q;
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] last_q;
  logic              urun_q;
  logic              at_last;

  assign at_last   = (tick_q == last_q);
  assign vec_ready = !run_q || at_last;
  assign load      = vec_valid && vec_ready;
  assign run       = run_q;
  assign tick      = tick_q;
  assign underrun  = urun_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      last_q <= '0;
      urun_q <= 1'b0;
    end else if (load) begin
      run_q  <= 1'b1;
      tick_q <= '0;
      last_q <= (vec_period == '0) ? '0 : vec_period - 1'b1;
    end else if (run_q) begin
      if (at_last) begin
        run_q  <= 1'b0;
        urun_q <= 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assert_load_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_ready) |=> (run_q && tick_q == '0));

  assert_tick_bound_R4: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (tick_q <= last_q));
endmodule

// File: rtl/wf_pin_fmt.sv
module wf_pin_fmt
  import wf_pkg::*;
#(
  parameter int CHR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHR_W-1:0]  chr_i,
  input  dir_e              dir_i,
  input  wave_ent_t         ent_i,
  input  logic              run_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [TICK_W-1:0] sdly_i,
  input  logic [TICK_W-1:0] rdly_i,
  input  logic              cmp_hi_i,
  input  logic              cmp_lo_i,
  output logic              oe_o,
  output logic              do_o,
  output logic              fail_o,
  output logic              fail_pulse_o
);
  localparam int SW = TICK_W + 1;

  logic   nop_q;
  dir_e   dir_q;
  logic   oe_q, do_q, fail_q, pulse_q;
  logic   [SW-1:0] tk, at1, at2, atr;
  logic   hit1, hit2, hitr, cmp_en, mism;
  logic   [1:0] st1, st2;

  function automatic logic [1:0] drive_step(drv_e a, dir_e d, logic oe, logic dv);
    logic [1:0] r;
    r = {oe, dv};
    if (d == DIR_IN) r = {1'b0, dv};
    else begin
      case (a)
        DRV_LOW:  r = 2'b10;
        DRV_HIGH: r = 2'b11;
        DRV_HOLD: r = {1'b1, dv};
        default:  r = {1'b0, dv};
      endcase
    end
    return r;
  endfunction

  always_comb begin
    tk   = {1'b0, tick_i};
    at1  = {1'b0, ent_i.t1} + {1'b0, sdly_i};
    at2  = {1'b0, ent_i.t2} + {1'b0, sdly_i};
    atr  = {1'b0, ent_i.tr} + {1'b0, rdly_i};
    hit1 = run_i && !nop_q && (tk == at1);
    hit2 = run_i && !nop_q && (tk == at2);
    hitr = run_i && !nop_q && (tk == atr);
    cmp_en = (dir_q != DIR_OUT) && (ent_i.cmp != CMP_NONE);
    case (ent_i.cmp)
      CMP_LOW:  mism = !cmp_lo_i;
      CMP_HIGH: mism = !cmp_hi_i;
      CMP_MID:  mism = cmp_hi_i || cmp_lo_i;
      default:  mism = 1'b0;
    endcase
    st1 = hit1 ? drive_step(ent_i.d1, dir_q, oe_q, do_q) : {oe_q, do_q};
    st2 = hit2 ? drive_step(ent_i.d2, dir_q, st1[1], st1[0]) : st1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nop_q   <= 1'b1;
      dir_q   <= DIR_IN;
      oe_q    <= 1'b0;
      do_q    <= 1'b0;
      fail_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      // edges of the period in flight use the vector state held before this load
      if (load) begin
        nop_q <= (chr_i == '0);
        dir_q <= dir_i;
      end
      {oe_q, do_q} <= st2;
      pulse_q <= hitr && cmp_en && mism;
      if (hitr && cmp_en && mism) fail_q <= 1'b1;
    end
  end

  assign oe_o         = oe_q;
  assign do_o         = do_q;
  assign fail_o       = fail_q;
  assign fail_pulse_o = pulse_q;

  assert_in_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> ($past(dir_q) != DIR_IN));

  assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !$fell(fail_q));

  assert_pulse_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> fail_q);
endmodule

// File: rtl/wf_formatter.sv
module wf_formatter
  import wf_pkg::*;
#(
  parameter int NPINS  = 4,
  parameter int NTBL   = 32,
  parameter int NCHR   = 16,
  localparam int TSEL_W = $clog2(NTBL),
  localparam int CHR_W  = $clog2(NCHR),
  localparam int DEPTH  = NTBL * NCHR
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tbl_we,
  input  logic [TSEL_W-1:0]        tbl_sel,
  input  logic [CHR_W-1:0]         tbl_chr,
  input  logic [ENT_W-1:0]         tbl_data,
  input  logic                     vec_valid,
  output logic                     vec_ready,
  input  logic [TSEL_W-1:0]        vec_tsel,
  input  logic [NPINS*CHR_W-1:0]   vec_chars,
  input  logic [NPINS*2-1:0]       vec_dir,
  input  logic [TICK_W-1:0]        vec_period,
  input  logic [NPINS*TICK_W-1:0]  pin_sdly,
  input  logic [NPINS*TICK_W-1:0]  pin_rdly,
  input  logic [NPINS-1:0]         cmp_hi,
  input  logic [NPINS-1:0]         cmp_lo,
  output logic [NPINS-1:0]         pin_do,
  output logic [NPINS-1:0]         pin_oe,
  output logic [NPINS-1:0]         pin_fail,
  output logic                     vec_fail,
  output logic                     underrun
);
  localparam int AW = TSEL_W + CHR_W;

  logic              load, run;
  logic [TICK_W-1:0] tick;
  logic [NPINS-1:0]  pulse;

  wf_period_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .vec_valid (vec_valid),
    .vec_period(vec_period),
    .vec_ready (vec_ready),
    .load      (load),
    .run       (run),
    .tick      (tick),
    .underrun  (underrun)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [ENT_W-1:0] row;
    logic [CHR_W-1:0] chr;
    assign chr = vec_chars[i*CHR_W +: CHR_W];

    // each pin owns a copy of the tables so all pins read in one cycle
    wf_table_ram #(.W(ENT_W), .DEPTH(DEPTH)) u_tbl (
      .clk   (clk),
      .we    (tbl_we),
      .waddr (AW'({tbl_sel, tbl_chr})),
      .wdata (tbl_data),
      .re    (load),
      .raddr (AW'({vec_tsel, chr})),
      .rdata (row)
    );

    wf_pin_fmt #(.CHR_W(CHR_W)) u_pin (
      .clk         (clk),
      .rst         (rst),
      .load        (load),
      .chr_i       (chr),
      .dir_i       (dir_e'(vec_dir[2*i +: 2])),
      .ent_i       (wave_ent_t'(row)),
      .run_i       (run),
      .tick_i      (tick),
      .sdly_i      (pin_sdly[i*TICK_W +: TICK_W]),
      .rdly_i      (pin_rdly[i*TICK_W +: TICK_W]),
      .cmp_hi_i    (cmp_hi[i]),
      .cmp_lo_i    (cmp_lo[i]),
      .oe_o        (pin_oe[i]),
      .do_o        (pin_do[i]),
      .fail_o      (pin_fail[i]),
      .fail_pulse_o(pulse[i])
    );
  end

  assign vec_fail = |pulse;

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> ($stable(pin_oe) && $stable(pin_do)));
endmodule

// File: tb/wf_formatter_bench.sv
`timescale 1ns/1ps
module wf_formatter_bench;
  localparam int NP = 4, NT = 4, NC = 16;
  localparam int TSW = 2, CW = 4, TW = 8, EW = 30;

  logic clk = 1'b0, rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [TSW-1:0] tbl_sel = '0;
  logic [CW-1:0] tbl_chr = '0;
  logic [EW-1:0] tbl_data = '0;
  logic vec_valid = 1'b0, vec_ready;
  logic [TSW-1:0] vec_tsel = '0;
  logic [NP*CW-1:0] vec_chars = '0;
  logic [NP*2-1:0] vec_dir = '0;
  logic [TW-1:0] vec_period = '0;
  logic [NP*TW-1:0] pin_sdly = '0, pin_rdly = '0;
  logic [NP-1:0] cmp_hi = '0, cmp_lo = '0;
  logic [NP-1:0] pin_do, pin_oe, pin_fail;
  logic vec_fail, underrun;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  wf_formatter #(.NPINS(NP), .NTBL(NT), .NCHR(NC)) u_wf_formatter (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_chr(tbl_chr),
    .tbl_data(tbl_data), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_tsel(vec_tsel), .vec_chars(vec_chars), .vec_dir(vec_dir),
    .vec_period(vec_period), .pin_sdly(pin_sdly), .pin_rdly(pin_rdly),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .pin_do(pin_do), .pin_oe(pin_oe),
    .pin_fail(pin_fail), .vec_fail(vec_fail), .underrun(underrun));

  typedef struct packed {
    logic [1:0] tsel; logic [3:0] chr;
    logic [1:0] d1; logic [1:0] d2; logic [1:0] cmp;
    logic [7:0] t1; logic [7:0] t2; logic [7:0] tr; logic [7:0] per;
    logic [1:0] dir; logic [7:0] sd; logic [7:0] rd; logic hi; logic lo;
  } case_t;

  // drive 0 low 1 high 2 hold 3 release; cmp 0 none 1 low 2 high 3 mid; dir 0 in 1 out 2 bidir
  localparam case_t CASES [11] = '{
    '{2'd0, 4'd1, 2'd1, 2'd0, 2'd0, 8'd1, 8'd4, 8'd0, 8'd8,  2'd2, 8'd0, 8'd0, 1'b0, 1'b0},
    '{2'd1, 4'd2, 2'd0, 2'd2, 2'd2, 8'd0, 8'd3, 8'd5, 8'd8,  2'd2, 8'd0, 8'd0, 1'b1, 1'b0},
    '{2'd2, 4'd3, 2'd3, 2'd3, 2'd2, 8'd2, 8'd3, 8'd1, 8'd8,  2'd2, 8'd0, 8'd0, 1'b0, 1'b1},
    '{2'd3, 4'd4, 2'd1, 2'd1, 2'd3, 8'd1, 8'd2, 8'd2, 8'd8,  2'd0, 8'd0, 8'd0, 1'b0, 1'b0},
    '{2'd0, 4'd5, 2'd1, 2'd2, 2'd3, 8'd0, 8'd1, 8'd2, 8'd8,  2'd2, 8'd1, 8'd1, 1'b1, 1'b0},
    '{2'd1, 4'd6, 2'd1, 2'd2, 2'd1, 8'd2, 8'd6, 8'd3, 8'd8,  2'd1, 8'd0, 8'd0, 1'b1, 1'b0},
    '{2'd2, 4'd7, 2'd0, 2'd1, 2'd1, 8'd1, 8'd5, 8'd2, 8'd4,  2'd2, 8'd0, 8'd1, 1'b0, 1'b1},
    '{2'd3, 4'd8, 2'd1, 2'd0, 2'd0, 8'd2, 8'd2, 8'd0, 8'd8,  2'd2, 8'd2, 8'd0, 1'b0, 1'b0},
    '{2'd0, 4'd0, 2'd1, 2'd1, 2'd2, 8'd0, 8'd0, 8'd0, 8'd8,  2'd2, 8'd0, 8'd0, 1'b0, 1'b0},
    '{2'd1, 4'd9, 2'd1, 2'd3, 2'd1, 8'd3, 8'd9, 8'd3, 8'd10, 2'd2, 8'd5, 8'd6, 1'b0, 1'b0},
    '{2'd2, 4'd10,2'd1, 2'd0, 2'd0, 8'd0, 8'd1, 8'd0, 8'd0,  2'd2, 8'd0, 8'd0, 1'b0, 1'b0}
  };

  // model state per pin
  logic m_oe [NP];
  logic m_do [NP];
  logic m_fl [NP];

  function automatic string case_tag(int idx);
    case (idx)
      3:       return "R7";
      5:       return "R7";
      6:       return "R4";
      7:       return "R5";
      8:       return "R9";
      10:      return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_row(logic [1:0] ts, logic [3:0] ch, logic [1:0] d1, logic [1:0] d2,
                        logic [1:0] cm, logic [7:0] t1, logic [7:0] t2, logic [7:0] tr);
    tbl_we = 1'b1; tbl_sel = ts; tbl_chr = ch; tbl_data = {d1, d2, cm, t1, t2, tr};
    @(posedge clk); @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic set_vec(logic [1:0] ts, logic [3:0] ch, logic [1:0] dr, logic [7:0] per);
    vec_tsel = ts; vec_period = per;
    for (int i = 0; i < NP; i++) begin
      vec_chars[i*CW +: CW] = ch;
      vec_dir[i*2 +: 2] = dr;
    end
  endtask

  task automatic model_step(logic [1:0] a, logic [1:0] dr, int i);
    if (dr == 2'd0) m_oe[i] = 1'b0;
    else case (a)
      2'd0: begin m_oe[i] = 1'b1; m_do[i] = 1'b0; end
      2'd1: begin m_oe[i] = 1'b1; m_do[i] = 1'b1; end
      2'd2: m_oe[i] = 1'b1;
      default: m_oe[i] = 1'b0;
    endcase
  endtask

  task automatic run_case(int idx);
    case_t c;
    int eff;
    string tg;
    c = CASES[idx];
    tg = case_tag(idx);
    eff = (c.per == 0) ? 1 : int'(c.per);
    for (int i = 0; i < NP; i++) begin
      pin_sdly[i*TW +: TW] = c.sd + 8'(i);
      pin_rdly[i*TW +: TW] = c.rd + 8'(i);
    end
    cmp_hi = {NP{c.hi}}; cmp_lo = {NP{c.lo}};
    wr_row(c.tsel, c.chr, c.d1, c.d2, c.cmp, c.t1, c.t2, c.tr);
    chk("R2", 32'(vec_ready), 32'd1);
    set_vec(c.tsel, c.chr, c.dir, c.per);
    vec_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    vec_valid = 1'b0;
    for (int k = 0; k < eff; k++) begin
      logic any;
      any = 1'b0;
      @(posedge clk); @(negedge clk);
      for (int i = 0; i < NP; i++) begin
        if (c.chr != 4'd0) begin
          if (k == int'(c.t1) + int'(c.sd) + i) model_step(c.d1, c.dir, i);
          if (k == int'(c.t2) + int'(c.sd) + i) model_step(c.d2, c.dir, i);
          if (k == int'(c.tr) + int'(c.rd) + i && c.dir != 2'd1 && c.cmp != 2'd0) begin
            logic bad;
            case (c.cmp)
              2'd1: bad = !c.lo;
              2'd2: bad = !c.hi;
              default: bad = c.hi || c.lo;
            endcase
            if (bad) begin any = 1'b1; m_fl[i] = 1'b1; end
          end
        end
        chk(tg, 32'(pin_oe[i]), 32'(m_oe[i]));
        chk(tg, 32'(pin_do[i]), 32'(m_do[i]));
        chk("R11", 32'(pin_fail[i]), 32'(m_fl[i]));
      end
      chk("R6", 32'(vec_fail), 32'(any));
    end
    chk("R10", 32'(underrun), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", 32'(pin_oe), 32'd0);
    chk("R1", 32'(pin_fail), 32'd0);
    chk("R1", 32'(underrun), 32'd0);
    chk("R1", 32'(vec_ready), 32'd1);

    // back-to-back vectors from two different tables (R2, R8)
    wr_row(2'd2, 4'd3, 2'd1, 2'd3, 2'd0, 8'd1, 8'd3, 8'd0);
    wr_row(2'd3, 4'd3, 2'd0, 2'd2, 2'd0, 8'd0, 8'd2, 8'd0);
    set_vec(2'd2, 4'd3, 2'd2, 8'd4);
    vec_valid = 1'b1;
    @(posedge clk); @(negedge clk);          // after load edge, tick 0
    set_vec(2'd3, 4'd3, 2'd2, 8'd4);
    chk("R2", 32'(vec_ready), 32'd0);
    @(posedge clk); @(negedge clk);          // tick 1
    chk("R2", 32'(vec_ready), 32'd0);
    @(posedge clk); @(negedge clk);          // tick 2, edge at tick 1 applied
    chk("R3", 32'(pin_oe), 32'hF);
    chk("R3", 32'(pin_do), 32'hF);
    @(posedge clk); @(negedge clk);          // tick 3 = last
    chk("R2", 32'(vec_ready), 32'd1);
    @(posedge clk); @(negedge clk);          // second vector tick 0, release applied
    vec_valid = 1'b0;
    chk("R3", 32'(pin_oe), 32'h0);
    chk("R2", 32'(underrun), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R8", 32'(pin_oe), 32'hF);
    chk("R8", 32'(pin_do), 32'h0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10", 32'(underrun), 32'd1);
    for (int i = 0; i < NP; i++) begin m_oe[i] = 1'b1; m_do[i] = 1'b0; m_fl[i] = 1'b0; end

    // table-driven cases
    for (int n = 0; n < 11; n++) run_case(n);

    // idle hold after underrun
    repeat (5) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      chk("R10", 32'(pin_oe[i]), 32'(m_oe[i]));
      chk("R10", 32'(pin_do[i]), 32'(m_do[i]));
      chk("R11", 32'(pin_fail[i]), 32'(m_fl[i]));
    end

    // reset again clears everything
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", 32'(pin_oe), 32'd0);
    chk("R1", 32'(pin_fail), 32'd0);
    chk("R1", 32'(underrun), 32'd0);
    chk("R1", 32'(vec_ready), 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule